// File: doc/BRIEF.md
# Dual-Base Periodic Interrupt Timer

This block is a four-channel periodic interrupt timer. Two shared 8-bit prescalers ("base timers") each emit a one-cycle tick every (base reload + 1) clock cycles. Each channel has a 16-bit down-counter that advances on the ticks of whichever base its select bit names. When a channel passes zero it reloads and raises a sticky time-out flag. A flag drives that channel's interrupt line whenever the channel's interrupt enable is set.

Software controls the block over a small synchronous register bus. It writes reload values, picks a base per channel, and turns channels on and off. It clears flags by writing ones. A channel's base can be swapped while the channel is counting, and the swap acts on the very next tick. The interrupt line is a registered level of flag AND enable. Enabling the interrupt while a flag is already pending therefore raises the line one cycle later.

Register map (4-bit address, 16-bit data; unused read bits are zero):
0x0 run control (bit 0), 0x1 channel enables, 0x2 flags (write 1 to clear), 0x3 base select, 0x4 interrupt enables, 0x5 base 0 reload, 0x6 base 1 reload, 0x8+i channel i reload, 0xC+i channel i live count (read only).

Top module: `pit_dual_base`

## Requirements
- R1: After reset every register at addresses 0x0 to 0xF reads as zero and `irq_o` is all zero.
- R2: The base select register (0x3) and the interrupt enable register (0x4) hold 4 bits, one per channel (bit i for channel i). They are readable and writable at any time, and bits 15:4 always read zero.
- R3: With run and channel enables set, the distance between successive time-outs of channel i is (B+1)×(L+1) clock cycles. Here B is the selected base reload and L is the channel reload (0x8+i).
- R4: Base select bit i = 0 makes channel i count on base 0 (reload at 0x5). A 1 makes it count on base 1 (reload at 0x6).
- R5: A change of a channel's select bit during a count takes effect on the next tick of the newly chosen base, with no wait for a reload or time-out.
- R6: A time-out sets bit i of the flag register (0x2). Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A time-out and a clear of the same bit in the same cycle leave the bit set.
- R7: `irq_o[i]` equals flag i AND interrupt enable i as held one cycle earlier. Setting the enable while the flag is pending raises `irq_o[i]` on the next cycle.
- R8: A channel counts only when run (0x0 bit 0) and its enable (0x1 bit i) are both 1. While it is disabled its count holds. On being enabled it loads its reload value.
- R9: Address 0xC+i returns channel i's current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 4 | Per-channel interrupt request levels, registered |

## Verification
The hardest situation to create is a base swap in the middle of a count. The time-out must land at a cycle fixed by the new base's tick phase, and that cycle must differ from the one the old base would give. The stimulus stops the run bit, programs the reloads, and restarts run at a known edge. This aligns both base timers with the channel load. The bench then flips the select bit at a chosen cycle and samples the flag on the cycles just before and just after the predicted time-out. A clear written on every cycle during the period runs forces a time-out and a clear into the same cycle on each expiry, so a lost flag pulse exposes a wrong priority.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_RUN     = 4'h0;
    localparam logic [ADDR_W-1:0] A_CHEN    = 4'h1;
    localparam logic [ADDR_W-1:0] A_FLAG    = 4'h2;
    localparam logic [ADDR_W-1:0] A_SEL     = 4'h3;
    localparam logic [ADDR_W-1:0] A_INTE    = 4'h4;
    localparam logic [ADDR_W-1:0] A_BASE0   = 4'h5;
    localparam logic [ADDR_W-1:0] A_LD_BASE = 4'h8;
    localparam logic [ADDR_W-1:0] A_CT_BASE = 4'hC;

    localparam int NBASE = 2;
endpackage

// File: rtl/pit_micro.sv
module pit_micro #(
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [MW-1:0] reload,
    output logic          tick
);
    typedef struct packed {
        logic [MW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    assign tick = en && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (!en || s_q.cnt == '0) begin
            s_d.cnt = reload;
        end else begin
            s_d.cnt = s_q.cnt - MW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pit_chan.sv
module pit_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] count,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ena;
    } st_t;

    st_t s_d, s_q;

    assign count = s_q.cnt;

    always_comb begin
        s_d     = s_q;
        expire  = 1'b0;
        s_d.ena = en;
        if (en && !s_q.ena) begin
            // fresh enable: start from the reload value
            s_d.cnt = reload;
        end else if (en && tick) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = reload;
                expire  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pit_dual_base.sv
module pit_dual_base
    import pit_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int MW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq_o
);
    typedef struct packed {
        logic                     run;
        logic [NCH-1:0]           chen;
        logic [NCH-1:0]           flag;
        logic [NCH-1:0]           sel;
        logic [NCH-1:0]           inte;
        logic [NCH-1:0]           irq;
        logic [NBASE-1:0][MW-1:0] bld;
        logic [NCH-1:0][CW-1:0]   cld;
    } regs_t;

    regs_t r_d, r_q;

    logic [NBASE-1:0]       base_tick;
    logic [NCH-1:0]         chan_en;
    logic [NCH-1:0]         chan_tick;
    logic [NCH-1:0]         expire;
    logic [NCH-1:0][CW-1:0] count;

    // signals exported for the bound checker
    logic [NCH-1:0]         flag_w;
    logic [NCH-1:0]         inte_w;
    logic [NCH-1:0][CW-1:0] cld_w;
    assign flag_w = r_q.flag;
    assign inte_w = r_q.inte;
    assign cld_w  = r_q.cld;

    for (genvar b = 0; b < NBASE; b++) begin : g_base
        pit_micro #(.MW(MW)) u_micro (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (r_q.run),
            .reload (r_q.bld[b]),
            .tick   (base_tick[b])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign chan_en[c]   = r_q.run & r_q.chen[c];
        assign chan_tick[c] = r_q.sel[c] ? base_tick[1] : base_tick[0];
        pit_chan #(.CW(CW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (chan_en[c]),
            .tick   (chan_tick[c]),
            .reload (r_q.cld[c]),
            .count  (count[c]),
            .expire (expire[c])
        );
    end

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            if (bus_addr == A_RUN)  r_d.run  = bus_wdata[0];
            if (bus_addr == A_CHEN) r_d.chen = bus_wdata[NCH-1:0];
            if (bus_addr == A_FLAG) r_d.flag = r_q.flag & ~bus_wdata[NCH-1:0];
            if (bus_addr == A_SEL)  r_d.sel  = bus_wdata[NCH-1:0];
            if (bus_addr == A_INTE) r_d.inte = bus_wdata[NCH-1:0];
            for (int b = 0; b < NBASE; b++) begin
                if (bus_addr == A_BASE0 + ADDR_W'(b)) r_d.bld[b] = bus_wdata[MW-1:0];
            end
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == A_LD_BASE + ADDR_W'(c)) r_d.cld[c] = bus_wdata[CW-1:0];
            end
        end
        // a time-out outranks a same-cycle clear
        r_d.flag = r_d.flag | expire;
        r_d.irq  = r_q.flag & r_q.inte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_RUN)  bus_rdata[0]       = r_q.run;
        if (bus_addr == A_CHEN) bus_rdata[NCH-1:0] = r_q.chen;
        if (bus_addr == A_FLAG) bus_rdata[NCH-1:0] = r_q.flag;
        if (bus_addr == A_SEL)  bus_rdata[NCH-1:0] = r_q.sel;
        if (bus_addr == A_INTE) bus_rdata[NCH-1:0] = r_q.inte;
        for (int b = 0; b < NBASE; b++) begin
            if (bus_addr == A_BASE0 + ADDR_W'(b)) bus_rdata[MW-1:0] = r_q.bld[b];
        end
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == A_LD_BASE + ADDR_W'(c)) bus_rdata[CW-1:0] = r_q.cld[c];
            if (bus_addr == A_CT_BASE + ADDR_W'(c)) bus_rdata[CW-1:0] = count[c];
        end
    end

    assign irq_o = r_q.irq;
endmodule

// File: rtl/pit_dual_base_chk.sv
module pit_dual_base_chk
    import pit_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         flag,
    input logic [NCH-1:0]         inte,
    input logic [NCH-1:0]         chan_en,
    input logic [NCH-1:0][CW-1:0] count,
    input logic [NCH-1:0][CW-1:0] cld
);
    logic [NCH-1:0] clr_mask;
    assign clr_mask = (bus_we && bus_addr == A_FLAG) ? bus_wdata[NCH-1:0] : '0;

    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(flag & inte));

    p_flag_w1c_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag) & ~flag & ~$past(clr_mask)) == '0));

    p_narrow_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SEL || bus_addr == A_INTE) |-> bus_rdata[DATA_W-1:NCH] == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[c] |=> count[c] == $past(count[c]));

        p_reload_on_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[c]) |-> count[c] == $past(cld[c]));
    end
endmodule

bind pit_dual_base pit_dual_base_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq_o),
    .flag      (flag_w),
    .inte      (inte_w),
    .chan_en   (chan_en),
    .count     (count),
    .cld       (cld_w)
);

// File: tb/tb_pit_dual_base.sv
module tb_pit_dual_base;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] irq_o;

    pit_dual_base dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    ch;
        int    per;
        string tag;
    } exp_t;
    exp_t sb[$];

    bit mon_on = 1'b0;
    int last_t[NCH];
    logic [NCH-1:0] prev_irq;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    // monitor: measure the spacing of irq pulses and score against the queue
    always @(negedge clk) begin
        if (!mon_on) begin
            for (int i = 0; i < NCH; i++) last_t[i] = -1;
            prev_irq = '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (irq_o[i] && !prev_irq[i]) begin
                    if (last_t[i] >= 0) begin
                        if (sb.size() == 0) begin
                            n_checks++; n_err++;
                            $display("FAIL R3 extra time-out ch%0d act=%0d exp=none", i, cyc - last_t[i]);
                        end else begin
                            exp_t e;
                            e = sb.pop_front();
                            n_checks++;
                            if (e.ch != i || (cyc - last_t[i]) != e.per) begin
                                n_err++;
                                $display("FAIL %s ch%0d period act=%0d exp=%0d (exp ch%0d)",
                                         e.tag, i, cyc - last_t[i], e.per, e.ch);
                            end
                        end
                    end
                    last_t[i] = cyc;
                end
            end
            prev_irq = irq_o;
        end
    end

    // driver: program one channel, push expected periods, clear flags every cycle
    task automatic run_period(int ch, int sel, int ld, int b0, int b1, string tag);
        int per;
        wr(4'h0, 16'h0);
        wr(4'h5, 16'(b0));
        wr(4'h6, 16'(b1));
        wr(4'h8 + 4'(ch), 16'(ld));
        wr(4'h3, 16'(sel << ch));
        wr(4'h1, 16'(1 << ch));
        wr(4'h4, 16'hF);
        wr(4'h2, 16'hF);
        per = ((sel != 0 ? b1 : b0) + 1) * (ld + 1);
        for (int k = 0; k < 3; k++) sb.push_back('{ch, per, tag});
        mon_on = 1'b1;
        wr(4'h0, 16'h1);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'h2; bus_wdata = 16'hF;   // R6: clear collides with each set
        for (int w = 0; w < 5 * per + 20 && sb.size() > 0; w++) @(negedge clk);
        bus_we = 1'b0;
        mon_on = 1'b0;
        if (sb.size() != 0) begin
            n_checks++; n_err++;
            $display("FAIL %s ch%0d missing time-outs act=%0d exp=0 (also R6)", tag, ch, sb.size());
            sb.delete();
        end
        wr(4'h0, 16'h0);
        wr(4'h1, 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL R3 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reg 0x%0h", a), v, 0);
        end
        chk("R1 irq_o", int'(irq_o), 0);

        // R2: narrow select / enable registers
        wr(4'h3, 16'hFFFF); rd(4'h3, v); chk("R2 select readback", v, 16'h000F);
        wr(4'h4, 16'h00A5); rd(4'h4, v); chk("R2 inte readback", v, 16'h0005);
        wr(4'h3, 16'h0);
        wr(4'h4, 16'h0);

        // R5 / R4: swap base of channel 0 mid-count, aligned start
        wr(4'h5, 16'd9);
        wr(4'h6, 16'd1);
        wr(4'h8, 16'd3);
        wr(4'h1, 16'h1);
        wr(4'h2, 16'hF);
        wr(4'h0, 16'h1);              // run captured at edge k, now mid cycle k
        repeat (10) @(negedge clk);
        wr(4'h3, 16'h1);              // select base 1 at edge k+12
        repeat (5) @(negedge clk);    // mid k+17
        rd(4'h2, v); chk("R5 flag before switched time-out", v & 1, 0);
        @(negedge clk);               // mid k+18
        rd(4'h2, v); chk("R5 flag at switched time-out", v & 1, 1);
        chk("R7 irq gated by disabled enable", int'(irq_o[0]), 0);
        wr(4'h1, 16'h0);              // disable ch0 at k+20, one base-1 tick later

        // R8 / R9: hold while disabled
        rd(4'hC, v); chk("R9 count after disable", v, 2);
        wr(4'h8, 16'd7);
        repeat (7) @(negedge clk);
        rd(4'hC, v); chk("R8 count holds while disabled", v, 2);

        // R6: writing 0 leaves a pending flag
        wr(4'h2, 16'h0);
        rd(4'h2, v); chk("R6 write 0 no effect", v & 1, 1);

        // R7: enabling with pending flag fires next cycle
        chk("R7 irq before enable", int'(irq_o[0]), 0);
        wr(4'h4, 16'h1);
        chk("R7 irq on enable edge", int'(irq_o[0]), 0);
        @(negedge clk);
        chk("R7 irq one cycle after enable", int'(irq_o[0]), 1);
        wr(4'h2, 16'h1);
        rd(4'h2, v); chk("R6 write 1 clears", v & 1, 0);
        chk("R7 irq still high right after clear", int'(irq_o[0]), 1);
        @(negedge clk);
        chk("R7 irq drops after clear", int'(irq_o[0]), 0);

        // R8: enabling loads the reload value
        wr(4'h1, 16'h1);
        rd(4'hC, v); chk("R8 count before load", v, 2);
        @(negedge clk);
        rd(4'hC, v); chk("R8 load on enable", v, 7);
        wr(4'h4, 16'h0);
        wr(4'h0, 16'h0);              // global stop
        rd(4'hC, v);
        repeat (9) @(negedge clk);
        rd(4'hC, v2); chk("R8 hold on global stop", v2, v);
        wr(4'h1, 16'h0);

        // R3 / R4: periods through the scoreboard
        run_period(0, 0, 4, 2, 4, "R4 base0");
        run_period(1, 0, 2, 2, 6, "R3 base0");
        run_period(2, 1, 1, 7, 4, "R4 base1");
        run_period(3, 1, 0, 3, 4, "R3 zero reload");

        summary();
        $finish;
    end
endmodule